// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns single internal access requests into cycles on an external bus. On that bus one 16-bit set of pins carries both address and data, and the upper address bits are held in an outside transparent latch. Each request gives an address, a direction, write data and a lane mode: narrow (8-bit data) or wide (16-bit data). The block then sequences the latch-enable, read and write strobes. It also chooses, per byte lane, when it drives the shared pins. Read results and a one-clock completion pulse come back on the internal side.

The latch-enable phase costs three clocks, so the block remembers the upper address it last latched. It issues a latch phase only when the new request's upper bits differ, or when that memory has been invalidated by reset or by a change of latch-enable polarity. Two settings are taken from configuration inputs: the polarity of the latch-enable pin and the length of the strobe. The request address is 24 bits wide. Bits 23:8 form the latched upper part and bits 7:0 form the low byte.

Top module: `mbus_master`

## Requirements
- R1: After reset the latch enable is at its inactive level, both strobes (active low) are high, neither lane is driven (`busAdOe` = 00) and `reqReady` is 1.
- R2: A data cycle is preceded by a latch phase exactly when no upper address is remembered, or when request bits 23:8 differ from the remembered value. The memory is empty after reset.
- R3: A latch phase lasts three clocks with `busAdOut` = address bits 23:8 and `busAdOe` = 11 throughout. The latch enable is active only in the middle clock.
- R4: With `cfgAleLow` = 0 the latch enable is active high. With `cfgAleLow` = 1 it idles high and pulses low. Any change of `cfgAleLow` empties the remembered upper address, so the next access issues a latch phase.
- R5: At most one of latch enable, read strobe and write strobe is active in any clock.
- R6: The read or write strobe stays low for `cfgCycLen`+1 consecutive clocks. The value is taken when the request is accepted.
- R7: Narrow mode (`reqWide` = 0): during the data cycle lane 1 (bits 15:8) carries address bits 7:0. Data uses lane 0 (bits 7:0). Writes drive lane 0 with write data bits 7:0.
- R8: Wide mode (`reqWide` = 1): no address is driven in the data cycle. A write drives all 16 write data bits on both lanes, and a read drives neither lane.
- R9: Read data is the value on `busAdIn` at the clock edge where the read strobe returns high, zero-extended from bits 7:0 in narrow mode. It appears on `rspData` with `rspValid` high in the clock after the strobe ends. Lane 0 is never driven while the read strobe is low.
- R10: A write drives both lanes with unchanged values for one clock before the write strobe falls and for one clock after it rises. `rspValid` is high in that hold clock.
- R11: After a read strobe there is one clock in which no lane is driven and `reqReady` is 0. Only then can a following cycle begin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; a request is accepted when both are high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 16-bit lanes, 0 = 8-bit lanes |
| reqAddr | input | 24 | Access address; bits 23:8 go through the external latch |
| reqWdata | input | 16 | Write data |
| cfgAleLow | input | 1 | Latch enable polarity, 1 = active low |
| cfgCycLen | input | 5 | Strobe length minus one, in clocks |
| rspValid | output | 1 | One-clock completion pulse |
| rspData | output | 16 | Read result, valid with rspValid after a read |
| busAle | output | 1 | Address latch enable |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busAdOut | output | 16 | Value for the shared pins |
| busAdOe | output | 2 | Per-lane drive enable; bit 1 = bits 15:8 |
| busAdIn | input | 16 | Value sampled from the shared pins |

## Verification
The assertions assume that `cfgAleLow` and `cfgCycLen` stay constant from acceptance until the completion pulse. They also assume that the external device returns read data within the programmed strobe length. The stimulus changes configuration only after every expected bus event and response has been seen and `reqReady` is high again. Its read device model drives the programmed value only while the read strobe is low and drives the complement otherwise.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE_SU,
    ST_ALE_ACT,
    ST_ALE_HD,
    ST_DAT_SU,
    ST_DAT_STB,
    ST_WR_HD,
    ST_RD_TURN
  } mbusState_e;

  typedef struct packed {
    logic loadReq;
    logic driveAle;
    logic aleOn;
    logic latchUpper;
    logic driveData;
    logic rdOn;
    logic wrOn;
    logic capture;
    logic done;
  } mbusStrobe_t;

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             needAle,
  input  logic             isWrite,
  input  logic [LEN_W-1:0] cycLen,
  output logic             reqReady,
  output mbusStrobe_t      stb
);

  mbusState_e       state, nextState;
  logic [LEN_W-1:0] cnt;
  logic             accept;
  logic             lastBeat;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;
  assign lastBeat = (state == ST_DAT_STB) && (cnt == '0);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (accept) nextState = needAle ? ST_ALE_SU : ST_DAT_SU;
      ST_ALE_SU:  nextState = ST_ALE_ACT;
      ST_ALE_ACT: nextState = ST_ALE_HD;
      ST_ALE_HD:  nextState = ST_DAT_SU;
      ST_DAT_SU:  nextState = ST_DAT_STB;
      ST_DAT_STB: if (lastBeat) nextState = isWrite ? ST_WR_HD : ST_RD_TURN;
      ST_WR_HD:   nextState = ST_IDLE;
      ST_RD_TURN: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_DAT_SU) begin
        cnt <= cycLen;
      end else if (state == ST_DAT_STB && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.loadReq    = accept;
    stb.driveAle   = (state == ST_ALE_SU) || (state == ST_ALE_ACT) || (state == ST_ALE_HD);
    stb.aleOn      = (state == ST_ALE_ACT);
    stb.latchUpper = (state == ST_ALE_ACT);
    stb.driveData  = (state == ST_DAT_SU) || (state == ST_DAT_STB) || (state == ST_WR_HD);
    stb.rdOn       = (state == ST_DAT_STB) && !isWrite;
    stb.wrOn       = (state == ST_DAT_STB) && isWrite;
    stb.capture    = lastBeat && !isWrite;
    stb.done       = (state == ST_WR_HD) || (state == ST_RD_TURN);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.aleOn, stb.rdOn, stb.wrOn})); // R5

  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> reqReady); // R9

  AST_NO_ACCEPT_IN_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.done && !isWrite) |-> !reqReady); // R11

endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int LEN_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mbusStrobe_t                   stb,
  input  logic                          reqWrite,
  input  logic                          reqWide,
  input  logic [AD_W+(AD_W/2)-1:0]      reqAddr,
  input  logic [AD_W-1:0]               reqWdata,
  input  logic                          cfgAleLow,
  input  logic [LEN_W-1:0]              cfgCycLen,
  input  logic [AD_W-1:0]               busAdIn,
  output logic                          needAle,
  output logic                          isWrite,
  output logic [LEN_W-1:0]              cycLen,
  output logic                          rspValid,
  output logic [AD_W-1:0]               rspData,
  output logic                          busAle,
  output logic                          busRdN,
  output logic                          busWrN,
  output logic [AD_W-1:0]               busAdOut,
  output logic [1:0]                    busAdOe
);

  localparam int LANE_W = AD_W / 2;
  localparam int ADDR_W = AD_W + LANE_W;
  localparam int LANES  = 2;

  logic [AD_W-1:0]   regUpper;
  logic [LANE_W-1:0] regLow;
  logic [AD_W-1:0]   regWdata;
  logic              regWrite;
  logic              regWide;
  logic [LEN_W-1:0]  regLen;
  logic [AD_W-1:0]   lastUpper;
  logic              lastValid;
  logic              prevPol;
  logic              polChanged;
  logic [AD_W-1:0]   rdData;

  assign polChanged = (cfgAleLow != prevPol);
  assign needAle    = !lastValid || polChanged || (reqAddr[ADDR_W-1:LANE_W] != lastUpper);
  assign isWrite    = regWrite;
  assign cycLen     = regLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regUpper  <= '0;
      regLow    <= '0;
      regWdata  <= '0;
      regWrite  <= 1'b0;
      regWide   <= 1'b0;
      regLen    <= '0;
      lastUpper <= '0;
      lastValid <= 1'b0;
      prevPol   <= 1'b0;
      rdData    <= '0;
    end else begin
      prevPol <= cfgAleLow;
      if (stb.loadReq) begin
        regUpper <= reqAddr[ADDR_W-1:LANE_W];
        regLow   <= reqAddr[LANE_W-1:0];
        regWdata <= reqWdata;
        regWrite <= reqWrite;
        regWide  <= reqWide;
        regLen   <= cfgCycLen;
      end
      if (stb.latchUpper) begin
        lastUpper <= regUpper;
      end
      if (polChanged) begin
        lastValid <= 1'b0;
      end else if (stb.latchUpper) begin
        lastValid <= 1'b1;
      end
      if (stb.capture) begin
        rdData <= regWide ? busAdIn : {{(AD_W-LANE_W){1'b0}}, busAdIn[LANE_W-1:0]};
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneOut;
    logic              laneOe;
    always_comb begin
      laneOut = '0;
      laneOe  = 1'b0;
      if (stb.driveAle) begin
        laneOut = regUpper[g*LANE_W +: LANE_W];
        laneOe  = 1'b1;
      end else if (stb.driveData) begin
        if (g == 1 && !regWide) begin
          laneOut = regLow;
          laneOe  = 1'b1;
        end else begin
          laneOut = regWdata[g*LANE_W +: LANE_W];
          laneOe  = regWrite;
        end
      end
    end
    assign busAdOut[g*LANE_W +: LANE_W] = laneOut;
    assign busAdOe[g]                   = laneOe;
  end

  assign busAle   = stb.aleOn ^ cfgAleLow;
  assign busRdN   = !stb.rdOn;
  assign busWrN   = !stb.wrOn;
  assign rspValid = stb.done;
  assign rspData  = rdData;

  logic aleActive;
  assign aleActive = (busAle != cfgAleLow);

  AST_ALE_ADDR_BEFORE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aleActive) |-> ($past(busAdOe) == 2'b11) && $stable(busAdOut)); // R3

  AST_ALE_ADDR_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aleActive) |-> (busAdOe == 2'b11) && $stable(busAdOut)); // R3

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN) && !(aleActive && (!busRdN || !busWrN))); // R5

  AST_WR_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busWrN) |-> ($past(busAdOe) == 2'b11) && $stable(busAdOut)); // R10

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWrN) |-> (busAdOe == 2'b11) && $stable(busAdOut) && rspValid); // R10

  AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrN && $past(!busWrN)) |-> $stable(busAdOut)); // R10

  AST_RD_LOW_LANE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busAdOe[0]); // R9

  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(!busRdN)) |-> (busAdOe == 2'b00)); // R11

endmodule

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int LEN_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqWrite,
  input  logic                     reqWide,
  input  logic [AD_W+(AD_W/2)-1:0] reqAddr,
  input  logic [AD_W-1:0]          reqWdata,
  input  logic                     cfgAleLow,
  input  logic [LEN_W-1:0]         cfgCycLen,
  output logic                     rspValid,
  output logic [AD_W-1:0]          rspData,
  output logic                     busAle,
  output logic                     busRdN,
  output logic                     busWrN,
  output logic [AD_W-1:0]          busAdOut,
  output logic [1:0]               busAdOe,
  input  logic [AD_W-1:0]          busAdIn
);

  mbusStrobe_t      stb;
  logic             needAle;
  logic             isWrite;
  logic [LEN_W-1:0] cycLen;

  mbus_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .needAle  (needAle),
    .isWrite  (isWrite),
    .cycLen   (cycLen),
    .reqReady (reqReady),
    .stb      (stb)
  );

  mbus_dpath #(.AD_W(AD_W), .LEN_W(LEN_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqWrite  (reqWrite),
    .reqWide   (reqWide),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .cfgAleLow (cfgAleLow),
    .cfgCycLen (cfgCycLen),
    .busAdIn   (busAdIn),
    .needAle   (needAle),
    .isWrite   (isWrite),
    .cycLen    (cycLen),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .busAle    (busAle),
    .busRdN    (busRdN),
    .busWrN    (busWrN),
    .busAdOut  (busAdOut),
    .busAdOe   (busAdOe)
  );

endmodule

// File: tb/mbus_master_tb_top.sv
module mbus_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int K_ALE = 0;
  localparam int K_RD  = 1;
  localparam int K_WR  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqWide = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        cfgAleLow = 1'b0;
  logic [4:0]  cfgCycLen = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        busAle, busRdN, busWrN;
  logic [15:0] busAdOut;
  logic [1:0]  busAdOe;
  logic [15:0] busAdIn;
  logic [15:0] rdModel = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign busAdIn = busRdN ? ~rdModel : rdModel;

  mbus_master dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgAleLow(cfgAleLow), .cfgCycLen(cfgCycLen), .rspValid(rspValid), .rspData(rspData),
    .busAle(busAle), .busRdN(busRdN), .busWrN(busWrN), .busAdOut(busAdOut),
    .busAdOe(busAdOe), .busAdIn(busAdIn)
  );

  typedef struct {
    int          kind;
    logic [15:0] ad;
    logic [1:0]  oe;
    int          len;
    bit          wide;
  } expItem_t;

  typedef struct {
    bit          isRead;
    logic [15:0] data;
  } rspItem_t;

  expItem_t expQ[$];
  rspItem_t rspQ[$];
  int nChecks = 0;
  int nErrors = 0;
  bit          benchValid = 1'b0;
  logic [15:0] benchUpper = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit wide, input logic [23:0] addr,
                        input logic [15:0] wd, input logic [15:0] rd);
    expItem_t it;
    rspItem_t rs;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    if (!benchValid || addr[23:8] != benchUpper) begin
      it.kind = K_ALE; it.ad = addr[23:8]; it.oe = 2'b11; it.len = 1; it.wide = wide;
      expQ.push_back(it);
      benchValid = 1'b1;
      benchUpper = addr[23:8];
    end
    it.kind = wr ? K_WR : K_RD;
    it.len  = int'(cfgCycLen) + 1;
    it.wide = wide;
    if (wr) begin
      it.oe = 2'b11;
      it.ad = wide ? wd : {addr[7:0], wd[7:0]};
    end else begin
      it.oe = wide ? 2'b00 : 2'b10;
      it.ad = wide ? 16'h0000 : {addr[7:0], 8'h00};
    end
    expQ.push_back(it);
    rs.isRead = !wr;
    rs.data   = wide ? rd : {8'h00, rd[7:0]};
    rspQ.push_back(rs);
    if (!wr) rdModel = rd;
    reqWrite = wr; reqWide = wide; reqAddr = addr; reqWdata = wd;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (expQ.size() != 0 || rspQ.size() != 0 || !reqReady) @(negedge clk);
  endtask

  bit          prevAle = 1'b0;
  bit          prevStr = 1'b0;
  bit          prevWrN = 1'b1;
  bit          prevRdN = 1'b1;
  logic [1:0]  prevOe = '0;
  logic [15:0] prevAd = '0;
  int          run = 0;

  always @(negedge clk) begin
    bit aleAct, strAct;
    expItem_t it;
    rspItem_t rs;
    logic [15:0] mask;
    if (rstN) begin
      aleAct = (busAle != cfgAleLow);
      strAct = !busRdN || !busWrN;
      chk(!(!busRdN && !busWrN) && !(aleAct && strAct), "R5",
          {29'd0, aleAct, busRdN, busWrN}, 32'd3);
      if (aleAct) begin
        chk(!prevAle, "R3", 32'd2, 32'd1);
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", 32'd1, 32'd0);
        end else begin
          it = expQ.pop_front();
          chk(it.kind == K_ALE, "R2", it.kind, K_ALE);
          chk(busAdOut == it.ad && busAdOe == 2'b11, "R3",
              {14'd0, busAdOe, busAdOut}, {14'd0, 2'b11, it.ad});
        end
      end
      if (strAct) begin
        run = prevStr ? run + 1 : 1;
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", 32'd1, 32'd0);
        end else begin
          it = expQ[0];
          if (!prevStr) chk(it.kind == (busWrN ? K_RD : K_WR), "R2", busWrN ? K_RD : K_WR, it.kind);
          mask = {{8{it.oe[1]}}, {8{it.oe[0]}}};
          chk(busAdOe == it.oe && (busAdOut & mask) == (it.ad & mask), it.wide ? "R8" : "R7",
              {14'd0, busAdOe, busAdOut & mask}, {14'd0, it.oe, it.ad & mask});
        end
      end else if (prevStr) begin
        if (expQ.size() != 0) begin
          it = expQ.pop_front();
          chk(run == it.len, "R6", run, it.len);
        end
      end
      if (!busWrN && prevWrN)
        chk(prevOe == 2'b11 && prevAd == busAdOut, "R10", {14'd0, prevOe, prevAd}, {14'd0, 2'b11, busAdOut});
      if (busWrN && !prevWrN)
        chk(busAdOe == 2'b11 && busAdOut == prevAd && rspValid, "R10",
            {13'd0, rspValid, busAdOe, busAdOut}, {13'd0, 1'b1, 2'b11, prevAd});
      if (rspValid) begin
        if (rspQ.size() == 0) begin
          chk(1'b0, "R9", 32'd1, 32'd0);
        end else begin
          rs = rspQ.pop_front();
          if (rs.isRead) begin
            chk(rspData == rs.data, "R9", rspData, rs.data);
            chk(!prevRdN, "R9", prevRdN, 32'd0);
            chk(busAdOe == 2'b00 && !reqReady, "R11", {29'd0, reqReady, busAdOe}, 32'd0);
          end
        end
      end
      prevAle = aleAct;
      prevStr = strAct;
      prevWrN = busWrN;
      prevRdN = busRdN;
      prevOe  = busAdOe;
      prevAd  = busAdOut;
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=expired expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busAle == 1'b0 && busRdN && busWrN && busAdOe == 2'b00 && reqReady, "R1",
        {27'd0, busAle, busRdN, busWrN, busAdOe}, {27'd0, 1'b0, 1'b1, 1'b1, 2'b00});

    cfgCycLen = 5'd0;
    access(1'b1, 1'b1, 24'h1234_10, 16'hBEEF, 16'h0);   // first access: latch phase (R2)
    drain();
    cfgCycLen = 5'd3;
    access(1'b0, 1'b1, 24'h1234_20, 16'h0, 16'hC0DE);   // same upper: no latch (R2, R8, R9)
    access(1'b1, 1'b0, 24'h5678_A5, 16'h003C, 16'h0);   // new upper (R7)
    access(1'b0, 1'b0, 24'h5678_42, 16'h0, 16'h9A7F);   // narrow read (R7, R9)
    drain();
    cfgCycLen = 5'd31;
    access(1'b1, 1'b1, 24'h5678_00, 16'h1357, 16'h0);   // long strobe (R6)
    drain();

    cfgAleLow = 1'b1;                                   // R4 polarity change
    benchValid = 1'b0;
    cfgCycLen = 5'd1;
    @(negedge clk);
    chk(busAle == 1'b1, "R4", busAle, 1'b1);
    access(1'b0, 1'b1, 24'h5678_10, 16'h0, 16'h2468);   // must relatch (R4)
    access(1'b1, 1'b0, 24'h5678_11, 16'h00E7, 16'h0);   // read then write: turnaround (R11)
    drain();

    cfgAleLow = 1'b0;
    benchValid = 1'b0;
    cfgCycLen = 5'd2;
    @(negedge clk);
    chk(busAle == 1'b0, "R4", busAle, 1'b0);
    access(1'b0, 1'b0, 24'hABCD_01, 16'h0, 16'h55AA);
    access(1'b0, 1'b1, 24'hABCD_02, 16'h0, 16'h0F0F);
    access(1'b1, 1'b1, 24'h0000_03, 16'hFFFF, 16'h0);
    drain();

    chk(expQ.size() == 0 && rspQ.size() == 0, "R2", expQ.size(), 32'd0);
    finishRun();
  end

endmodule